// File: doc/BRIEF.md
# Majority-Vote Serial Receiver

This block turns an asynchronous serial line into characters. It counts oversampling ticks to time each bit, and it decides each bit by a two-of-three vote, so a short spike on the line cannot flip a bit. It assembles 7- or 8-bit characters, least significant bit first. An optional parity bit can be checked in one of four modes. The finished character is placed in a status word, together with its error flags.

Software talks to the block through a small word-wide register bus. The controller writes the settings, the tick divisor and a flow-control stop character. It then either polls or watches the data-available output. It consumes each character by reading the popping status address or by writing an acknowledge bit. When a clean character equals the stop character, a one-cycle pulse goes out to a neighbouring transmitter. An active-low ready-to-send output follows a control bit.

Top module: `uart_rx_major`

## Requirements
- R1: After reset, dav_o is 0, rts_no is 1, and the status word at address 2 reads 0.
- R2: A bit lasts 8*(div+1) clocks, where div is addr 1 bits [7:0]. Each bit is the majority of samples taken at ticks 3, 4 and 5 of its 8 ticks, so a line disturbance that spans only one sample does not change the bit.
- R3: A low line that is high again at the start bit's mid-bit vote is treated as a glitch, and no character results.
- R4: Data arrives LSB first. Control bit 1 selects 8 bits (1) or 7 bits (0). In 7-bit mode, status bit 7 reads 0.
- R5: Control bit 2 enables parity. Control bits [4:3] select the mode: 00 even, 01 odd, 10 mark (bit is 1), 11 space (bit is 0). A mismatch sets status bit 10.
- R6: A stop bit that votes low sets the framing flag, status bit 9. A line break therefore reads as data 0x00 with bit 9 set.
- R7: A finished character sets dav_o and status bit 8. Either a read of address 3 or a write to address 2 with bit 0 set clears them. A plain read of address 2 does not clear them.
- R8: If a character finishes while dav is still set and no acknowledge comes in that cycle, status bit 11 (overrun) is set, and the new data replaces the old.
- R9: If an acknowledge and a character completion fall in the same cycle, the acknowledge consumes the old character. The new character remains, with dav 1 and overrun 0.
- R10: When control bit 0 (enable) is 0, no character is captured.
- R11: rts_no is the inverse of control bit 5.
- R12: xoff_match_o pulses for one cycle when a character with no framing or parity error equals the stop character, addr 1 bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effect on addr 3) |
| addr_i | input | 2 | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data (combinational from addr_i) |
| dav_o | output | 1 | Character waiting |
| rts_no | output | 1 | Ready-to-send, active low |
| xoff_match_o | output | 1 | Stop-character match pulse |

## Verification
Completion of a character and an acknowledge from software can land in the same clock. The bench provokes this by writing the acknowledge bit every cycle during the stop bit of a second frame, and it stops as soon as the new data becomes visible. The collision edge is therefore one where both happen. The result is judged correct if the new character is still pending with no overrun. An acknowledge-first ordering would lose the new character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W = 8;
  localparam int DIV_W  = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_POP  = 2'd3;

  typedef enum logic [1:0] {PAR_EVEN, PAR_ODD, PAR_MARK, PAR_SPACE} par_mode_e;

  typedef struct packed {
    logic      rts;
    par_mode_e par_mode;
    logic      par_en;
    logic      len8;
    logic      en;
  } rx_ctrl_t;

  typedef struct packed {
    logic              ovr;
    logic              pe;
    logic              fe;
    logic              dav;
    logic [CHAR_W-1:0] data;
  } rx_stat_t;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} rx_state_e;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen import uart_rx_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/rx_frame.sv
module rx_frame import uart_rx_pkg::*; #(
  parameter int OSR         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              len8_i,
  input  logic              par_en_i,
  input  par_mode_e         par_mode_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              fe_o,
  output logic              pe_o
);
  localparam int PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] SMP_A   = PH_W'(OSR/2 - 1);
  localparam logic [PH_W-1:0] SMP_B   = PH_W'(OSR/2);
  localparam logic [PH_W-1:0] SMP_C   = PH_W'(OSR/2 + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
  localparam int CNT_W = $clog2(CHAR_W);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rxd_s;
  rx_state_e              state_q;
  logic [PH_W-1:0]        phase_q;
  logic [CNT_W-1:0]       bit_cnt_q;
  logic [CHAR_W-1:0]      shreg_q;
  logic                   s_a_q, s_b_q, par_q, armed_q;
  logic                   vote, exp_par;
  logic [CHAR_W-1:0]      aligned;
  logic [CNT_W-1:0]       last_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
  end
  assign rxd_s = sync_q[SYNC_STAGES-1];

  assign vote     = (s_a_q & s_b_q) | (s_a_q & rxd_s) | (s_b_q & rxd_s);
  assign aligned  = len8_i ? shreg_q : {1'b0, shreg_q[CHAR_W-1:1]};
  assign last_idx = len8_i ? CNT_W'(CHAR_W - 1) : CNT_W'(CHAR_W - 2);

  always_comb begin
    case (par_mode_i)
      PAR_EVEN: exp_par = ^aligned;
      PAR_ODD:  exp_par = ~^aligned;
      PAR_MARK: exp_par = 1'b1;
      default:  exp_par = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= '0;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      s_a_q     <= 1'b1;
      s_b_q     <= 1'b1;
      par_q     <= 1'b0;
      armed_q   <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      fe_o      <= 1'b0;
      pe_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        phase_q <= '0;
        armed_q <= 1'b0;
      end else if (tick_i) begin
        if (state_q == ST_IDLE) begin
          if (rxd_s) armed_q <= 1'b1;
          else if (armed_q) begin
            state_q <= ST_START;
            phase_q <= PH_W'(1);
          end
        end else begin
          phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
          if (phase_q == SMP_A) s_a_q <= rxd_s;
          if (phase_q == SMP_B) s_b_q <= rxd_s;
          if (phase_q == SMP_C) begin
            case (state_q)
              ST_START: begin
                if (vote) state_q <= ST_IDLE;  // glitch
                else begin
                  state_q   <= ST_DATA;
                  bit_cnt_q <= '0;
                end
              end
              ST_DATA: begin
                shreg_q   <= {vote, shreg_q[CHAR_W-1:1]};
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (bit_cnt_q == last_idx) state_q <= par_en_i ? ST_PAR : ST_STOP;
              end
              ST_PAR: begin
                par_q   <= vote;
                state_q <= ST_STOP;
              end
              ST_STOP: begin
                done_o  <= 1'b1;
                data_o  <= aligned;
                fe_o    <= !vote;
                pe_o    <= par_en_i && (par_q != exp_par);
                armed_q <= vote;  // after a break wait for idle high
                state_q <= ST_IDLE;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  p_no_capture_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !done_o);
  p_start_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && $past(state_q) == ST_IDLE) |-> $past(tick_i));
endmodule

// File: rtl/rx_regs.sv
module rx_regs import uart_rx_pkg::*; #(
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              done_i,
  input  logic [CHAR_W-1:0] cdata_i,
  input  logic              cfe_i,
  input  logic              cpe_i,
  output rx_ctrl_t          ctrl_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DW-1:0]     rdata_o,
  output logic              dav_o,
  output logic              xoff_match_o
);
  localparam int CTRL_W = $bits(rx_ctrl_t);
  localparam int STAT_W = $bits(rx_stat_t);

  rx_ctrl_t          ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [CHAR_W-1:0] xoff_q;
  rx_stat_t          stat_q;
  logic              ack;

  assign ack = (wr_en_i && addr_i == ADDR_STAT && wdata_i[0]) ||
               (rd_en_i && addr_i == ADDR_POP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= '0;
      xoff_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_CTRL) ctrl_q <= rx_ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (addr_i == ADDR_CFG) begin
        div_q  <= wdata_i[DIV_W-1:0];
        xoff_q <= wdata_i[DIV_W +: CHAR_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q       <= '0;
      xoff_match_o <= 1'b0;
    end else begin
      xoff_match_o <= done_i && !cfe_i && !cpe_i && (cdata_i == xoff_q);
      if (done_i) begin
        stat_q.data <= cdata_i;
        stat_q.fe   <= cfe_i;
        stat_q.pe   <= cpe_i;
        stat_q.ovr  <= stat_q.dav && !ack;
        stat_q.dav  <= 1'b1;
      end else if (ack) begin
        stat_q.dav <= 1'b0;
        stat_q.fe  <= 1'b0;
        stat_q.pe  <= 1'b0;
        stat_q.ovr <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      ADDR_CFG:  rdata_o[DIV_W+CHAR_W-1:0] = {xoff_q, div_q};
      default:   rdata_o[STAT_W-1:0] = stat_q;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign div_o  = div_q;
  assign dav_o  = stat_q.dav;

  p_dav_on_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> dav_o);
  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !done_i) |=> !dav_o);
  p_ovr_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && dav_o && !ack) |=> stat_q.ovr);
  p_keep_new_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ack) |=> (dav_o && !stat_q.ovr));
  p_xoff_after_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xoff_match_o |-> $past(done_i));
endmodule

// File: rtl/uart_rx_major.sv
module uart_rx_major import uart_rx_pkg::*; #(
  parameter int DW          = 16,
  parameter int OSR         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rxd_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          dav_o,
  output logic          rts_no,
  output logic          xoff_match_o
);
  rx_ctrl_t          ctrl;
  logic [DIV_W-1:0]  div;
  logic              tick, done, cfe, cpe;
  logic [CHAR_W-1:0] cdata;

  rx_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .done_i(done), .cdata_i(cdata), .cfe_i(cfe), .cpe_i(cpe),
    .ctrl_o(ctrl), .div_o(div), .rdata_o, .dav_o, .xoff_match_o
  );

  rx_tick_gen u_tick (
    .clk_i, .rst_ni, .run_i(ctrl.en), .div_i(div), .tick_o(tick)
  );

  rx_frame #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_frame (
    .clk_i, .rst_ni, .en_i(ctrl.en), .len8_i(ctrl.len8), .par_en_i(ctrl.par_en),
    .par_mode_i(ctrl.par_mode), .tick_i(tick), .rxd_i,
    .done_o(done), .data_o(cdata), .fe_o(cfe), .pe_o(cpe)
  );

  assign rts_no = ~ctrl.rts;
endmodule

// File: tb/uart_rx_major_bench.sv
module uart_rx_major_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIVV       = 4;
  localparam int BIT        = 8 * (DIVV + 1);
  localparam int NVEC       = 10;
  // {len8, par_en, mode[1:0], data[7:0], parbit, stop, exp_data[7:0], exp_fe, exp_pe}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 2'd0, 8'h55, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0},
    {1'b1, 1'b1, 2'd0, 8'hA3, 1'b0, 1'b1, 8'hA3, 1'b0, 1'b0},
    {1'b1, 1'b1, 2'd1, 8'h0F, 1'b1, 1'b1, 8'h0F, 1'b0, 1'b0},
    {1'b1, 1'b1, 2'd0, 8'h01, 1'b0, 1'b1, 8'h01, 1'b0, 1'b1},
    {1'b0, 1'b0, 2'd0, 8'hBC, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0},
    {1'b0, 1'b1, 2'd2, 8'h41, 1'b1, 1'b1, 8'h41, 1'b0, 1'b0},
    {1'b0, 1'b1, 2'd3, 8'h41, 1'b1, 1'b1, 8'h41, 1'b0, 1'b1},
    {1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b1, 2'd1, 8'hC8, 1'b0, 1'b0, 8'hC8, 1'b1, 1'b0},
    {1'b0, 1'b1, 2'd0, 8'h7F, 1'b1, 1'b1, 8'h7F, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rxd = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        dav, rts_n, xoff_match;
  int          n_run = 0, n_fail = 0, xoff_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (xoff_match) xoff_cnt <= xoff_cnt + 1;

  uart_rx_major u_uart_rx_major (
    .clk_i(clk), .rst_ni, .rxd_i(rxd), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .dav_o(dav),
    .rts_no(rts_n), .xoff_match_o(xoff_match)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(output logic [15:0] d);
    @(negedge clk); addr = 2'd2; #1 d = rdata;
  endtask

  task automatic pop(output logic [15:0] d);
    @(negedge clk); addr = 2'd3; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic logic [15:0] ctrl_w(input bit en, input bit len8, input bit pen,
                                         input logic [1:0] mode, input bit rts);
    return {10'b0, rts, mode, pen, len8, en};
  endfunction

  task automatic send_bit(input logic v, input bit glitch);
    for (int i = 0; i < BIT; i++) begin
      rxd = (glitch && i >= 20 && i < 23) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input bit len8, input bit pen, input logic pbit,
                            input logic [7:0] d, input logic stop, input int gbit);
    @(negedge clk);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < (len8 ? 8 : 7); i++) send_bit(d[i], gbit == i);
    if (pen) send_bit(pbit, 1'b0);
    send_bit(stop, 1'b0);
    send_bit(1'b1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] s;
    int          x0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    peek(s);
    check("R1 status", s, 16'h0000);
    check("R1 dav", {15'b0, dav}, 16'h0000);
    check("R1 rts", {15'b0, rts_n}, 16'h0001);
    // R11 rts follows control bit
    bus_wr(2'd1, {8'h13, 8'(DIVV)});
    bus_wr(2'd0, ctrl_w(1, 1, 0, 2'd0, 1));
    check("R11 rts asserted", {15'b0, rts_n}, 16'h0000);
    bus_wr(2'd0, ctrl_w(1, 1, 0, 2'd0, 0));
    check("R11 rts released", {15'b0, rts_n}, 16'h0001);
    repeat (BIT) @(negedge clk);

    // table: R4 R5 R6 R7
    for (int k = 0; k < NVEC; k++) begin
      logic [23:0] v;
      v = VEC[k];
      bus_wr(2'd0, ctrl_w(1, v[23], v[22], v[21:20], 0));
      send_frame(v[23], v[22], v[11], v[19:12], v[10], -1);
      pop(s);
      check($sformatf("R4 data vec%0d", k), {8'h0, s[7:0]}, {8'h0, v[9:2]});
      check($sformatf("R6 fe vec%0d", k), {15'b0, s[9]}, {15'b0, v[1]});
      check($sformatf("R5 pe vec%0d", k), {15'b0, s[10]}, {15'b0, v[0]});
      check($sformatf("R7 dav vec%0d", k), {15'b0, s[8]}, 16'h0001);
      check($sformatf("R7 pop clears vec%0d", k), {15'b0, dav}, 16'h0000);
      repeat (BIT) @(negedge clk);
    end

    bus_wr(2'd0, ctrl_w(1, 1, 0, 2'd0, 0));
    // R2 one corrupted sample per bit is outvoted
    send_frame(1, 0, 0, 8'h96, 1, 0);
    pop(s);
    check("R2 glitch bit0", {8'h0, s[7:0]}, 16'h0096);
    send_frame(1, 0, 0, 8'h96, 1, 5);
    pop(s);
    check("R2 glitch bit5", {8'h0, s[7:0]}, 16'h0096);

    // R3 short low pulse is no start bit
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    check("R3 no char from glitch", {15'b0, dav}, 16'h0000);
    send_frame(1, 0, 0, 8'h3A, 1, -1);
    pop(s);
    check("R3 next frame ok", {8'h0, s[7:0]}, 16'h003A);

    // R7 peek keeps, write-ack clears
    send_frame(1, 0, 0, 8'h61, 1, -1);
    peek(s);
    peek(s);
    check("R7 peek keeps dav", {15'b0, dav}, 16'h0001);
    bus_wr(2'd2, 16'h0001);
    check("R7 write ack clears", {15'b0, dav}, 16'h0000);

    // R8 overrun
    send_frame(1, 0, 0, 8'h11, 1, -1);
    send_frame(1, 0, 0, 8'h22, 1, -1);
    pop(s);
    check("R8 new data kept", {8'h0, s[7:0]}, 16'h0022);
    check("R8 overrun flag", {15'b0, s[11]}, 16'h0001);

    // R9 ack in the completion cycle
    send_frame(1, 0, 0, 8'h5A, 1, -1);
    fork
      send_frame(1, 0, 0, 8'hA5, 1, -1);
      begin
        int g;
        g = 0;
        repeat (9 * BIT) @(negedge clk);
        addr = 2'd2; wdata = 16'h0001;
        #1;
        while (rdata[7:0] != 8'hA5 && g < 4 * BIT) begin
          wr_en = 1'b1;
          @(negedge clk); #1;
          g++;
        end
        wr_en = 1'b0;
      end
    join
    peek(s);
    check("R9 data", {8'h0, s[7:0]}, 16'h00A5);
    check("R9 dav kept", {15'b0, s[8]}, 16'h0001);
    check("R9 no overrun", {15'b0, s[11]}, 16'h0000);
    pop(s);

    // R10 disabled receiver ignores frames
    bus_wr(2'd0, ctrl_w(0, 1, 0, 2'd0, 0));
    send_frame(1, 0, 0, 8'hE7, 1, -1);
    peek(s);
    check("R10 no dav", {15'b0, dav}, 16'h0000);
    check("R10 data unchanged", {8'h0, s[7:0]}, 16'h00A5);
    bus_wr(2'd0, ctrl_w(1, 1, 0, 2'd0, 0));
    repeat (2 * BIT) @(negedge clk);

    // R12 stop-character match
    x0 = xoff_cnt;
    send_frame(1, 0, 0, 8'h13, 1, -1);
    check("R12 match pulse", 16'(xoff_cnt - x0), 16'd1);
    pop(s);
    x0 = xoff_cnt;
    send_frame(1, 0, 0, 8'h14, 1, -1);
    check("R12 no match", 16'(xoff_cnt - x0), 16'd0);
    pop(s);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule